// File: doc/BRIEF.md
# Monte Carlo Pi Sampling Lane

This block is a single lane of a hardware pi estimator. On every enabled clock it draws one point in the unit square and tests whether it falls inside the quarter circle of radius one. It also keeps two running totals: how many points were drawn and how many landed inside. The ratio of hits to samples tends to pi/4. Higher levels of the chip combine lanes and perform the division.

Two 32-bit linear congruential generators supply the coordinates. They use different multiplier/increment families, so that x and y do not share lattice structure. The coordinate is the upper 23 bits of the freshly advanced state, read as an unsigned fraction. The square of x is formed in a first registered stage. It is then fed as the addend of a multiply-add that squares y, so one fused operation yields the sum of squares. That sum is compared against 1.0 in Q1.46.

A seed port reloads both generator states while the lane is idle, and the same write clears the totals. Seed writes that arrive while sampling is enabled are dropped.

Top module: `mc_pi_lane`

## Requirements
- R1: When `en_i` is high at a clock edge, the x state advances as s = 1664525*s + 1013904223 mod 2^32. The x coordinate of that sample is bits [31:9] of the new state, read as an unsigned fraction x/2^23.
- R2: The y state advances on the same edge as s = 1103515245*s + 12345 mod 2^32. The y coordinate of that sample is bits [31:9] of the new y state.
- R3: A sample is a hit exactly when x*x + y*y <= 2^46, where x and y are the 23-bit integer coordinates (1.0 in Q1.46).
- R4: `hit_vld_o` is high during the cycle after the second clock edge that follows an edge sampling `en_i` high, and `hit_o` then carries that sample's result. `hit_vld_o` is low in every cycle that no such sample reaches.
- R5: `smp_cnt_o` increments by one on the edge that ends each cycle in which `hit_vld_o` is high.
- R6: `hit_cnt_o` increments by one on the edge that ends each cycle in which both `hit_vld_o` and `hit_o` are high. Otherwise it holds.
- R7: `seed_we_i` high with `en_i` low at an edge loads `seed_x_i` and `seed_y_i` into the x and y states, clears both counters and drops any sample still in the pipeline.
- R8: `seed_we_i` high while `en_i` is high has no effect. The states advance as in R1/R2 and the counters are not cleared.
- R9: After reset both counters are zero, `hit_vld_o` and `hit_o` are low, the x state is 32'h0000_0001 and the y state is 32'h0000_0002.
- R10: With `en_i` low and no seed load, both generator states hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Draw one sample per cycle while high |
| seed_we_i | input | 1 | Seed write strobe, honoured only while `en_i` is low |
| seed_x_i | input | 32 | New x generator state |
| seed_y_i | input | 32 | New y generator state |
| hit_o | output | 1 | Inside-circle result of the sample in the output stage |
| hit_vld_o | output | 1 | `hit_o` carries a sample this cycle |
| hit_cnt_o | output | 64 | Number of hits since reset or seed load |
| smp_cnt_o | output | 64 | Number of samples since reset or seed load |

## Verification
A wrong generator state or coordinate slice is invisible in the counters. It shows only as a `hit_o` value that disagrees with an independent model of both streams, two cycles after the affected draw. The stream check therefore compares every sample of long runs against such a model, including runs that pause and resume. Targeted seeds place coordinates at zero, at full scale and just either side of the unit circle. An error in the comparison width or boundary then flips `hit_o` on the exact sample concerned. Counter or flush faults appear one cycle after the valid flag, and one cycle after a seed load.

// File: rtl/mc_pi_pkg.sv
package mc_pi_pkg;
  localparam int unsigned STATE_W = 32;
  localparam int unsigned COORD_W = 23;
  localparam int unsigned SQ_W    = 2 * COORD_W;
  localparam int unsigned SUM_W   = SQ_W + 1;
  localparam int unsigned CNT_W   = 64;

  // x and y come from distinct LCG families
  localparam logic [STATE_W-1:0] X_MUL = 32'd1664525;
  localparam logic [STATE_W-1:0] X_INC = 32'd1013904223;
  localparam logic [STATE_W-1:0] Y_MUL = 32'd1103515245;
  localparam logic [STATE_W-1:0] Y_INC = 32'd12345;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [COORD_W-1:0] coord_t;
endpackage

// File: rtl/mc_pi_lcg.sv
module mc_pi_lcg #(
  parameter int unsigned W        = 32,
  parameter int unsigned CW       = 23,
  parameter logic [W-1:0] MUL     = 32'd1664525,
  parameter logic [W-1:0] INC     = 32'd1013904223,
  parameter logic [W-1:0] RST_VAL = 32'd1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [W-1:0]  seed_i,
  output logic [CW-1:0] coord_o
);
  logic [W-1:0] state_q, nxt;

  assign nxt     = state_q * MUL + INC;
  assign coord_o = nxt[W-1 -: CW];  // coordinate of the state about to be stored

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RST_VAL;
    else if (load_i) state_q <= seed_i;
    else if (step_i) state_q <= nxt;
  end

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/mc_pi_hit_test.sv
module mc_pi_hit_test
  import mc_pi_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vld_i,
  input  logic   flush_i,
  input  coord_t x_i,
  input  coord_t y_i,
  output logic   hit_o,
  output logic   vld_o
);
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1) << SQ_W;

  logic [SQ_W-1:0]  xsq_q;
  coord_t           y_q;
  logic             v1_q, v2_q, hit_q;
  logic [SUM_W-1:0] sum_d, sum_q;

  // stage 1: square x, carry y
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xsq_q <= '0;
      y_q   <= '0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= vld_i && !flush_i;
      if (vld_i) begin
        xsq_q <= SQ_W'(x_i) * SQ_W'(x_i);
        y_q   <= y_i;
      end
    end
  end

  // stage 2: y*y with x*x on the addend port
  assign sum_d = SUM_W'(y_q) * SUM_W'(y_q) + SUM_W'(xsq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      hit_q <= 1'b0;
      v2_q  <= 1'b0;
    end else begin
      v2_q <= v1_q && !flush_i;
      if (v1_q) begin
        sum_q <= sum_d;
        hit_q <= (sum_d <= ONE);
      end
    end
  end

  assign hit_o = hit_q;
  assign vld_o = v2_q;

  // R3
  hit_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_q |-> (hit_q == (sum_q <= ONE)));

  // R4
  stage_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_q |-> $past(v1_q));
endmodule

// File: rtl/mc_pi_tally.sv
module mc_pi_tally #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic          hit_i,
  output logic [CW-1:0] hit_cnt_o,
  output logic [CW-1:0] smp_cnt_o
);
  logic [CW-1:0] hit_q, smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= '0;
      smp_q <= '0;
    end else if (clr_i) begin
      hit_q <= '0;
      smp_q <= '0;
    end else if (vld_i) begin
      smp_q <= smp_q + CW'(1);
      hit_q <= hit_q + CW'(hit_i);
    end
  end

  assign hit_cnt_o = hit_q;
  assign smp_cnt_o = smp_q;

  // R5
  smp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i) |=> (smp_q == $past(smp_q) + CW'(1)));

  // R6
  hit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q <= smp_q);

  // R6
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(vld_i && hit_i)) |=> $stable(hit_q));
endmodule

// File: rtl/mc_pi_lane.sv
module mc_pi_lane
  import mc_pi_pkg::*;
#(
  parameter logic [31:0] RST_SEED_X = 32'h0000_0001,
  parameter logic [31:0] RST_SEED_Y = 32'h0000_0002
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        seed_we_i,
  input  logic [31:0] seed_x_i,
  input  logic [31:0] seed_y_i,
  output logic        hit_o,
  output logic        hit_vld_o,
  output logic [63:0] hit_cnt_o,
  output logic [63:0] smp_cnt_o
);
  logic   seed_ld;
  coord_t x_c, y_c;
  logic   vld, hit;

  assign seed_ld = seed_we_i && !en_i;  // seeds only while idle

  mc_pi_lcg #(.W(STATE_W), .CW(COORD_W), .MUL(X_MUL), .INC(X_INC), .RST_VAL(RST_SEED_X)) u_lcg_x (
    .clk_i, .rst_ni, .step_i(en_i), .load_i(seed_ld), .seed_i(seed_x_i), .coord_o(x_c)
  );

  mc_pi_lcg #(.W(STATE_W), .CW(COORD_W), .MUL(Y_MUL), .INC(Y_INC), .RST_VAL(RST_SEED_Y)) u_lcg_y (
    .clk_i, .rst_ni, .step_i(en_i), .load_i(seed_ld), .seed_i(seed_y_i), .coord_o(y_c)
  );

  mc_pi_hit_test u_hit (
    .clk_i, .rst_ni, .vld_i(en_i), .flush_i(seed_ld),
    .x_i(x_c), .y_i(y_c), .hit_o(hit), .vld_o(vld)
  );

  mc_pi_tally #(.CW(CNT_W)) u_tally (
    .clk_i, .rst_ni, .clr_i(seed_ld), .vld_i(vld), .hit_i(hit),
    .hit_cnt_o, .smp_cnt_o
  );

  assign hit_o     = hit;
  assign hit_vld_o = vld;

  // R4
  vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_vld_o |-> $past(en_i, 2));

  // R7
  seed_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_we_i && !en_i) |=> (smp_cnt_o == '0 && hit_cnt_o == '0 && !hit_vld_o));

  // R8
  seed_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_we_i && en_i && !hit_vld_o) |=> (smp_cnt_o == $past(smp_cnt_o)));
endmodule

// File: tb/sim_mc_pi_lane.sv
`timescale 1ns/1ps
module sim_mc_pi_lane;
  localparam logic [31:0] MX = 32'd1664525, IX = 32'd1013904223;
  localparam logic [31:0] MY = 32'd1103515245, IY = 32'd12345;

  // stimulus: {x coord, y coord}; expected hit derived from R3
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {23'h000000, 23'h000000},
    {23'h7FFFFF, 23'h000000},
    {23'h7FFFFF, 23'h7FFFFF},
    {23'h5A8279, 23'h5A8279},
    {23'h5A827A, 23'h5A827A},
    {23'h400000, 23'h6ED9EB},
    {23'h000000, 23'h7FFFFF},
    {23'h123456, 23'h654321}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, seed_we = 1'b0;
  logic [31:0] seed_x = '0, seed_y = '0;
  logic hit, hit_vld;
  logic [63:0] hit_cnt, smp_cnt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] msx, msy;
  logic        prev_e;
  longint      tot_hit, tot_smp;

  always #2.5 clk = ~clk;

  mc_pi_lane u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_we_i(seed_we),
    .seed_x_i(seed_x), .seed_y_i(seed_y), .hit_o(hit), .hit_vld_o(hit_vld),
    .hit_cnt_o(hit_cnt), .smp_cnt_o(smp_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] inv32(input logic [31:0] a);
    logic [31:0] v = a;
    for (int k = 0; k < 5; k++) v = v * (32'd2 - a * v);
    return v;
  endfunction

  function automatic bit hit_of(input logic [22:0] x, input logic [22:0] y);
    logic [63:0] s = 64'(x) * 64'(x) + 64'(y) * 64'(y);
    return s <= 64'h4000_0000_0000;
  endfunction

  task automatic load_seed(input logic [31:0] sx, input logic [31:0] sy);
    @(negedge clk);
    seed_we = 1'b1; seed_x = sx; seed_y = sy; en = 1'b0;
    @(negedge clk);
    seed_we = 1'b0;
    msx = sx; msy = sy; tot_hit = 0; tot_smp = 0;
  endtask

  // enabled run of n samples, every result compared against the model
  task automatic stream(input int n, input bit pulse);
    bit e;
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      msx = msx * MX + IX;
      msy = msy * MY + IY;
      e = hit_of(msx[31:9], msy[31:9]);
      tot_smp++;
      if (e) tot_hit++;
      seed_we = pulse && (i == n / 2);
      seed_x  = 32'hFFFF_0000;
      seed_y  = 32'h0000_FFFF;
      @(negedge clk);
      if (i > 0) chk(hit_vld && hit == prev_e, "R1 R2 R3 stream", {62'd0, hit_vld, hit}, {62'd0, 1'b1, prev_e});
      prev_e = e;
    end
    en = 1'b0; seed_we = 1'b0;
    @(negedge clk);
    chk(hit_vld && hit == prev_e, "R4 last sample", {62'd0, hit_vld, hit}, {62'd0, 1'b1, prev_e});
    @(negedge clk);
    chk(!hit_vld, "R4 valid drops", 64'(hit_vld), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    logic [31:0] tx, ty;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(smp_cnt == 0 && hit_cnt == 0, "R9 counters", smp_cnt | hit_cnt, 64'd0);
    chk(!hit_vld && !hit, "R9 flags", {62'd0, hit_vld, hit}, 64'd0);
    msx = 32'h1; msy = 32'h2; tot_hit = 0; tot_smp = 0;
    stream(3, 1'b0);
    chk(smp_cnt == 64'(tot_smp), "R9 R5 reset seeds count", smp_cnt, 64'(tot_smp));
    chk(hit_cnt == 64'(tot_hit), "R9 R6 reset seeds hits", hit_cnt, 64'(tot_hit));

    // table walk: seed so the next state carries the chosen coordinate
    for (int v = 0; v < NV; v++) begin
      tx = {VEC[v][45:23], 9'h0A5};
      ty = {VEC[v][22:0], 9'h15B};
      e  = hit_of(VEC[v][45:23], VEC[v][22:0]);
      load_seed((tx - IX) * inv32(MX), (ty - IY) * inv32(MY));
      chk(smp_cnt == 0 && hit_cnt == 0, "R7 seed clears", smp_cnt | hit_cnt, 64'd0);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      chk(!hit_vld, "R4 not early", 64'(hit_vld), 64'd0);
      @(negedge clk);
      chk(hit_vld, "R4 valid", 64'(hit_vld), 64'd1);
      chk(hit == e, "R3 boundary vector", 64'(hit), 64'(e));
      @(negedge clk);
      chk(smp_cnt == 1, "R5 one sample", smp_cnt, 64'd1);
      chk(hit_cnt == 64'(e), "R6 hit tally", hit_cnt, 64'(e));
    end

    // R7 flush: seed load while a sample is in flight
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0; seed_we = 1'b1; seed_x = 32'h5; seed_y = 32'h6;
    @(negedge clk);
    seed_we = 1'b0;
    chk(!hit_vld && smp_cnt == 0, "R7 flush", {63'd0, hit_vld} | smp_cnt, 64'd0);
    @(negedge clk);
    chk(smp_cnt == 0, "R7 no late count", smp_cnt, 64'd0);

    // long stream with ignored seed write (R8) and a pause (R10)
    load_seed(32'hDEAD_BEEF, 32'h0BAD_F00D);
    stream(120, 1'b1);
    repeat (5) @(negedge clk);
    stream(80, 1'b0);
    chk(smp_cnt == 64'(tot_smp), "R5 R8 stream samples", smp_cnt, 64'(tot_smp));
    chk(hit_cnt == 64'(tot_hit), "R6 R10 stream hits", hit_cnt, 64'(tot_hit));

    summary();
  end
endmodule